// File: doc/BRIEF.md
# Four-Channel Scaled-Compare PWM Timer

This peripheral counts clock cycles in a 31-bit counter and compares a 16-bit slice of that counter against four compare registers. Each compare channel has a pending flag and an interrupt line. A prescale field chooses where the slice starts: the slice is the counter shifted right by the scale amount. This lets one counter width cover periods from a few cycles to billions of cycles.

Software controls the block through a flat 32-bit register bus. Writes are single-cycle strobes. Reads are combinational from the addressed register. Counting can run continuously or as a one-shot. A one-shot disarms itself when the counter wraps, or when channel 0 matches with the restart option enabled. The restart option returns the counter to zero, so channel 0 sets the period.

Software can load the counter in two ways: as a raw value, or through the scaled view, where the written value is shifted up by the scale amount.

Top module: `cmpwm_timer`

## Requirements
- R1: After reset the configuration, counter and all compare registers read as zero, and every interrupt line is low.
- R2: The counter advances by one each clock while either the always-run bit (config bit 12) or the one-shot bit (config bit 13) is set, and holds otherwise. Offset 0x08 returns the counter with bit 31 reading 0.
- R3: Offset 0x10 returns the counter shifted right by the scale field (config bits 3:0), keeping 16 bits.
- R4: The compare registers sit at 0x20, 0x24, 0x28 and 0x2C for channels 0 to 3. Each stores 16 bits, and the upper 16 bits read as zero.
- R5: One cycle after the scaled count is greater than or equal to a channel's compare value, that channel's pending bit (config bit 28+i) and its interrupt line go high. This happens whether the counter is running or stopped.
- R6: When the restart bit (config bit 9) is set and channel 0 matches, the counter becomes zero on the next clock and the one-shot bit clears.
- R7: When a running counter steps from 0x7FFFFFFF to 0, the one-shot bit clears. The always-run bit is untouched and counting continues.
- R8: A write to 0x08 loads counter bits 30:0 from data bits 30:0. A write to 0x10 loads data bits 15:0 shifted left by the current scale, truncated to 31 bits. Either load takes priority over the restart and the increment in the same cycle.
- R9: A config write replaces all four pending bits with data bits 31:28. A zero lowers that interrupt on the next clock, and a one raises it. The config write also takes priority over a one-shot clear in the same cycle.
- R10: Unmapped offsets read as zero, and writes to them change nothing. Config bits other than 3:0, 9, 12, 13 and 31:28 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr, combinational |
| irq | output | NCH (4) | Per-channel interrupt, equal to the pending bits |

## Verification
The bench builds the block with its defaults: four channels, a 31-bit counter and 16-bit compares. With these values the full wrap point 0x7FFFFFFF is reachable in two cycles by loading the counter directly, and scale values up to 15 reach counter bits above the 16-bit window. Random configuration writes combine restart, one-shot and always-run with arbitrary pending masks and scales. A bench model predicts every read and interrupt value cycle by cycle.

// File: rtl/cmpwm_pkg.sv
package cmpwm_pkg;

    // Register offsets (byte addresses)
    localparam int unsigned OFS_CFG   = 32'h00;
    localparam int unsigned OFS_CNT   = 32'h08;
    localparam int unsigned OFS_SCL   = 32'h10;
    localparam int unsigned OFS_CMP0  = 32'h20;
    localparam int unsigned CMP_STEP  = 4;

    // Config field positions
    localparam int unsigned SCALE_W   = 4;
    localparam int unsigned BIT_ZC    = 9;
    localparam int unsigned BIT_ALW   = 12;
    localparam int unsigned BIT_ONCE  = 13;
    localparam int unsigned PEND_LSB  = 28;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic               zero_cmp;
        logic               run_always;
        logic               run_once;
    } cfg_t;

endpackage

// File: rtl/cmpwm_counter.sv
module cmpwm_counter #(
    parameter int CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             zero_req,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap_hit
);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d    = cnt_q;
        wrap_hit = 1'b0;
        if (ld_en) begin
            cnt_d = ld_val;
        end else if (zero_req) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d    = cnt_q + 1'b1;
            wrap_hit = &cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/cmpwm_chan.sv
module cmpwm_chan #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] scaled,
    input  logic [CMP_W-1:0] cmp_val,
    input  logic             wr_en,
    input  logic             wr_val,
    output logic             match,
    output logic             pend_q
);

    logic pend_d;

    always_comb begin
        match  = (scaled >= cmp_val);
        pend_d = wr_en ? wr_val : (pend_q | match);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

endmodule

// File: rtl/cmpwm_timer.sv
module cmpwm_timer
    import cmpwm_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 31,
    parameter int CMP_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    irq
);

    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_CNT);
    localparam logic [ADDR_W-1:0] A_SCL = ADDR_W'(OFS_SCL);

    cfg_t             cfg_d, cfg_q;
    logic [CMP_W-1:0] cmp_d [NCH];
    logic [CMP_W-1:0] cmp_q [NCH];

    logic             cfg_wr, cnt_wr, scl_wr, cnt_ld, run, zero_hit, wrap_hit;
    logic [NCH-1:0]   cmp_wr, match_vec, pend_vec;
    logic [CNT_W-1:0] cnt_val, ld_val, scl_ld, shifted;
    logic [CMP_W-1:0] scaled;

    // Decode
    always_comb begin
        cfg_wr = bus_we && (bus_addr == A_CFG);
        cnt_wr = bus_we && (bus_addr == A_CNT);
        scl_wr = bus_we && (bus_addr == A_SCL);
        for (int i = 0; i < NCH; i++) begin
            cmp_wr[i] = bus_we && (bus_addr == ADDR_W'(OFS_CMP0 + i * CMP_STEP));
        end
    end

    // Counter datapath
    always_comb begin
        run      = cfg_q.run_always | cfg_q.run_once;
        shifted  = cnt_val >> cfg_q.scale;
        scaled   = shifted[CMP_W-1:0];
        scl_ld   = CNT_W'(bus_wdata[CMP_W-1:0]) << cfg_q.scale;
        cnt_ld   = cnt_wr | scl_wr;
        ld_val   = cnt_wr ? bus_wdata[CNT_W-1:0] : scl_ld;
        zero_hit = cfg_q.zero_cmp & match_vec[0];
    end

    cmpwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .ld_en    (cnt_ld),
        .ld_val   (ld_val),
        .zero_req (zero_hit),
        .cnt_q    (cnt_val),
        .wrap_hit (wrap_hit)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        cmpwm_chan #(.CMP_W(CMP_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .scaled  (scaled),
            .cmp_val (cmp_q[g]),
            .wr_en   (cfg_wr),
            .wr_val  (bus_wdata[PEND_LSB + g]),
            .match   (match_vec[g]),
            .pend_q  (pend_vec[g])
        );
    end

    // Register next-state
    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d.scale      = bus_wdata[SCALE_W-1:0];
            cfg_d.zero_cmp   = bus_wdata[BIT_ZC];
            cfg_d.run_always = bus_wdata[BIT_ALW];
            cfg_d.run_once   = bus_wdata[BIT_ONCE];
        end else if (zero_hit || wrap_hit) begin
            cfg_d.run_once = 1'b0;
        end
        for (int i = 0; i < NCH; i++) begin
            cmp_d[i] = cmp_wr[i] ? bus_wdata[CMP_W-1:0] : cmp_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            for (int i = 0; i < NCH; i++) cmp_q[i] <= '0;
        end else begin
            cfg_q <= cfg_d;
            for (int i = 0; i < NCH; i++) cmp_q[i] <= cmp_d[i];
        end
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CFG) begin
            bus_rdata[SCALE_W-1:0]        = cfg_q.scale;
            bus_rdata[BIT_ZC]             = cfg_q.zero_cmp;
            bus_rdata[BIT_ALW]            = cfg_q.run_always;
            bus_rdata[BIT_ONCE]           = cfg_q.run_once;
            bus_rdata[PEND_LSB +: NCH]    = pend_vec;
        end else if (bus_addr == A_CNT) begin
            bus_rdata = DATA_W'(cnt_val);
        end else if (bus_addr == A_SCL) begin
            bus_rdata = DATA_W'(scaled);
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == ADDR_W'(OFS_CMP0 + i * CMP_STEP)) begin
                    bus_rdata = DATA_W'(cmp_q[i]);
                end
            end
        end
    end

    assign irq = pend_vec;

endmodule

// File: rtl/cmpwm_timer_chk.sv
module cmpwm_timer_chk #(
    parameter int NCH    = 4,
    parameter int CNT_W  = 31,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic              cnt_wr,
    input logic [DATA_W-1:0] wdata,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              run,
    input logic              cnt_ld,
    input logic              zero_hit,
    input logic [NCH-1:0]    match_vec,
    input logic [NCH-1:0]    irq
);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !cnt_ld && !zero_hit && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_ld && !zero_hit) |=> $stable(cnt_q));

    // R6
    zero_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_hit && !cnt_ld) |=> (cnt_q == '0));

    // R5
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ((irq & $past(match_vec)) == $past(match_vec)));

    // R9
    irq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (irq == $past(wdata[28 +: NCH])));

    // R8
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(wdata[CNT_W-1:0])));

endmodule

bind cmpwm_timer cmpwm_timer_chk #(.NCH(NCH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cnt_wr    (cnt_wr),
    .wdata     (bus_wdata),
    .cnt_q     (cnt_val),
    .run       (run),
    .cnt_ld    (cnt_ld),
    .zero_hit  (zero_hit),
    .match_vec (match_vec),
    .irq       (irq)
);

// File: tb/test_cmpwm_timer.sv
module test_cmpwm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    cmpwm_timer i_cmpwm_timer (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Reference model state
    logic [30:0] m_cnt = '0;
    logic [3:0]  m_scale = '0;
    logic        m_zc = 0, m_al = 0, m_os = 0;
    logic [3:0]  m_pend = '0;
    logic [15:0] m_cmp [4] = '{default: '0};

    function automatic logic [15:0] m_scaled();
        logic [30:0] s;
        s = m_cnt >> m_scale;
        return s[15:0];
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] r;
        r = '0;
        case (a)
            8'h00: begin
                r[3:0] = m_scale; r[9] = m_zc; r[12] = m_al; r[13] = m_os;
                r[31:28] = m_pend;
            end
            8'h08: r = {1'b0, m_cnt};
            8'h10: r = {16'h0, m_scaled()};
            8'h20: r = {16'h0, m_cmp[0]};
            8'h24: r = {16'h0, m_cmp[1]};
            8'h28: r = {16'h0, m_cmp[2]};
            8'h2C: r = {16'h0, m_cmp[3]};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00: return "R9";
            8'h08: return "R2";
            8'h10: return "R3";
            8'h20, 8'h24, 8'h28, 8'h2C: return "R4";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called just after a negedge; leaves just after the next negedge.
    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                        input string tag = "");
        logic [15:0] sc;
        logic [3:0]  mt;
        logic        zh, run, cntw, sclw, cfgw, wrapped;
        logic [30:0] n_cnt, tmp;
        bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        if (!we) check((tag == "") ? tag_of(a) : tag, bus_rdata, m_read(a));
        check("R5", {28'h0, irq}, {28'h0, m_pend});
        sc  = m_scaled();
        for (int i = 0; i < 4; i++) mt[i] = (sc >= m_cmp[i]);
        run  = m_al | m_os;
        zh   = m_zc & mt[0];
        cfgw = we && a == 8'h00;
        cntw = we && a == 8'h08;
        sclw = we && a == 8'h10;
        wrapped = 1'b0;
        tmp = 31'(d[15:0]);
        if (cntw)      n_cnt = d[30:0];
        else if (sclw) n_cnt = tmp << m_scale;
        else if (zh)   n_cnt = '0;
        else if (run) begin n_cnt = m_cnt + 1'b1; wrapped = &m_cnt; end
        else           n_cnt = m_cnt;
        @(posedge clk);
        m_cnt = n_cnt;
        if (cfgw) begin
            m_scale = d[3:0]; m_zc = d[9]; m_al = d[12]; m_os = d[13]; m_pend = d[31:28];
        end else begin
            m_pend = m_pend | mt;
            if (zh || wrapped) m_os = 1'b0;
        end
        for (int i = 0; i < 4; i++) if (we && a == 8'(8'h20 + 4 * i)) m_cmp[i] = d[15:0];
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, input string tag = "");
        step(1'b0, a, 32'h0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d);
    endtask

    initial begin
        #(5 * 190000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        // R1: state during reset
        #12;
        foreach (m_cmp[k]) begin end
        bus_addr = 8'h00; #1; check("R1", bus_rdata, 32'h0);
        bus_addr = 8'h08; #1; check("R1", bus_rdata, 32'h0);
        bus_addr = 8'h2C; #1; check("R1", bus_rdata, 32'h0);
        check("R1", {28'h0, irq}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        rd(8'h20, "R1");

        // R4: compare width
        wr(8'h20, 32'hDEAD_FFFF); wr(8'h24, 32'h1234_ABCD);
        wr(8'h28, 32'h0000_FFFF); wr(8'h2C, 32'hFFFF_FFFF);
        rd(8'h20); rd(8'h24); rd(8'h2C);
        wr(8'h00, 32'h0);                 // clear pending, stopped
        // R8 + R3: scaled load with scale 4
        wr(8'h00, 32'h0000_0004);
        wr(8'h10, 32'hFFFF_ABCD);
        rd(8'h08, "R8"); rd(8'h10, "R3");
        // R5: channel 1 (cmp 0xABCD) matched while stopped
        rd(8'h00, "R5");
        check("R5", {31'h0, irq[1]}, 32'h1);
        // R9: clear pending; interrupt low next cycle
        wr(8'h00, 32'h0000_0004);
        check("R9", {28'h0, irq}, 32'h0);
        wr(8'h00, 32'hA000_0000);
        check("R9", {28'h0, irq}, 32'hA);
        // R8: raw count load, bit 31 ignored
        wr(8'h08, 32'hFFFF_FFF0);
        rd(8'h08, "R8");
        // R7: one-shot wrap
        wr(8'h00, 32'h0000_2000);
        wr(8'h08, 32'h7FFF_FFFE);
        rd(8'h00, "R7"); rd(8'h00, "R7"); rd(8'h08, "R7"); rd(8'h00, "R7");
        check("R7", bus_rdata & 32'h3000, 32'h0);
        // R7: always-run keeps going through wrap
        wr(8'h00, 32'h0000_1000);
        wr(8'h08, 32'h7FFF_FFFF);
        rd(8'h08, "R7"); rd(8'h08, "R7");
        // R6: restart on channel 0
        wr(8'h20, 32'h5);
        wr(8'h00, 32'h0000_3200);
        wr(8'h08, 32'h0);
        for (int k = 0; k < 12; k++) rd(8'h08, "R6");
        rd(8'h00, "R6");
        check("R6", bus_rdata & 32'h2000, 32'h0);
        // R8: load beats increment and restart
        wr(8'h08, 32'h0000_0003);
        rd(8'h08, "R8");
        // R10: unmapped offsets
        wr(8'h04, 32'hFFFF_FFFF); wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h04, "R10"); rd(8'h40, "R10"); rd(8'h14, "R10");
        rd(8'h00, "R10");
        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic [7:0]  a;
            logic [31:0] d;
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0: a = 8'h00;
                1: a = 8'h08;
                2: a = 8'h10;
                3, 4: a = 8'(8'h20 + 4 * $urandom_range(0, 3));
                5: a = 8'(4 * $urandom_range(0, 20));
                default: a = 8'(8 * $urandom_range(0, 6));
            endcase
            d = $urandom;
            if (a == 8'h08 && d[0]) d = 32'h7FFF_FFF0 | (d & 32'hF);
            if ($urandom_range(0, 3) == 0) step(1'b1, a, d);
            else step(1'b0, a, 32'h0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule